// File: doc/BRIEF.md
# Shared-Prescaler Multichannel PWM Generator

This block drives a bank of pulse-width-modulated outputs from one input clock. A prescaler divides the input clock into a slower tick. Every channel shares one 8-bit tick counter that runs from 0 to 255 and then wraps, so the PWM period is always 256 ticks. The only way to change that period is to change the shared prescaler. Each channel has its own 8-bit compare value, which sets how many ticks its output stays high at the start of each period.

Software writes the configuration through a small write-only register port. The prescaler is written as two 4-bit halves. The per-channel compare values are written one per address. All written values are first held in a staging copy. The live copy takes them over only when the counter wraps from 255 to 0, so a running waveform never shows a partial period. A per-channel enable input gates each output. The counter runs only while at least one channel is enabled. While no channel is enabled, the counter is held at 0 and the staged values pass straight through to the live copy. Working out a prescaler value from a requested period is left to software.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low, and the staged and live prescaler and compare values are all 0.
- R2: A write to address 0 puts wr_data[3:0] into prescaler bits 3:0. A write to address 1 puts wr_data[3:0] into prescaler bits 7:4. Neither write changes the other half, and wr_data[7:4] is ignored for both.
- R3: With a live prescaler value ps, one tick lasts ps+1 input clocks, and one PWM period lasts (ps+1)*256 input clocks.
- R4: An enabled channel with live compare value N (N below 255) is high for the first (N+1)*(ps+1) input clocks of each period and low for the rest of it.
- R5: A compare value of 0 gives a high pulse of exactly one tick, that is ps+1 input clocks, in every period.
- R6: A compare value of 255 holds an enabled output high without a break.
- R7: All channels share the same counter, so every enabled channel with a compare value below 255 rises in the same input clock cycle at the start of a period.
- R8: Register writes change only the staged values. While any channel is enabled, the live values take over the staged values only when the counter wraps from 255 to 0. While no channel is enabled, the live values take over the staged values on every clock, so a newly enabled channel starts at once with the latest values.
- R9: A channel whose enable is low has a low output. The counter keeps running while any channel is enabled. When no channel is enabled, the counter is held at tick 0 and the prescaler count is held at 0.
- R10: A write to address 2+k sets the compare value of channel k, for k from 0 to 3. Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address: 0 = prescaler low half, 1 = prescaler high half, 2+k = compare value of channel k |
| wr_data | input | CNT_W (8) | Write data |
| chan_en | input | NUM_CH (4) | Per-channel output enable |
| pwm_out | output | NUM_CH (4) | PWM outputs |

## Verification
The hardest case to reach is a compare write that arrives part way through a running period. The output must keep the old high time until the wrap and switch to the new one only in the following period. The bench lines up on a rising edge of the channel, writes a new compare value a few cycles later, and checks that the current pulse still ends at the old length while the next pulse has the new length. A second hard case is the idle path. The bench disables every channel, writes a new value, and enables one channel; the new value must then apply from the very first cycle. A cycle-accurate behavioural model runs alongside and checks the outputs on every clock.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    // register address map of the write port
    localparam int unsigned PS_LO_ADDR    = 0;
    localparam int unsigned PS_HI_ADDR    = 1;
    localparam int unsigned CMP_BASE_ADDR = 2;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  ps_act,
    output logic [CNT_W-1:0] cnt,
    output logic [PS_W-1:0]  div,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [PS_W-1:0]  div;
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.div == ps_act);
        wrap = tick && (st_q.cnt == CNT_TOP);
        if (!run) begin
            st_d = '0;
        end else if (tick) begin
            st_d.div = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign div = st_q.div;
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         load,
    output logic [PS_W-1:0]              ps_act,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_act
);
    localparam int NIB_W = PS_W / 2;
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(PS_LO_ADDR);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(PS_HI_ADDR);

    typedef struct packed {
        logic [PS_W-1:0]              ps_stage;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp_stage;
        logic [PS_W-1:0]              ps_live;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp_live;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // live copy takes the staging copy as it stood before this cycle's write
        if (load) begin
            st_d.ps_live  = st_q.ps_stage;
            st_d.cmp_live = st_q.cmp_stage;
        end
        if (wr_en) begin
            if (wr_addr == A_LO)
                st_d.ps_stage[NIB_W-1:0] = wr_data[NIB_W-1:0];
            if (wr_addr == A_HI)
                st_d.ps_stage[PS_W-1:NIB_W] = wr_data[NIB_W-1:0];
            for (int k = 0; k < NUM_CH; k++) begin
                if (wr_addr == ADDR_W'(CMP_BASE_ADDR + k))
                    st_d.cmp_stage[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ps_act  = st_q.ps_live;
    assign cmp_act = st_q.cmp_live;
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
    parameter int CNT_W = 8
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             out
);
    always_comb begin
        out = en && (cnt <= cmp);
    end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] pwm_out
);
    logic                         run;
    logic                         period_wrap;
    logic                         cfg_load;
    logic [CNT_W-1:0]             tick_cnt;
    logic [PS_W-1:0]              tick_div;
    logic [PS_W-1:0]              ps_act;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;

    always_comb begin
        run      = |chan_en;
        cfg_load = period_wrap || !run;
    end

    pwm_tick_gen #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ps_act (ps_act),
        .cnt    (tick_cnt),
        .div    (tick_div),
        .wrap   (period_wrap)
    );

    pwm_cfg_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (cfg_load),
        .ps_act  (ps_act),
        .cmp_act (cmp_act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
            .en  (chan_en[g]),
            .cnt (tick_cnt),
            .cmp (cmp_act[g]),
            .out (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            chan_en,
    input logic [CNT_W-1:0]             cnt,
    input logic [PS_W-1:0]              div,
    input logic [PS_W-1:0]              ps_act,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
    input logic                         wrap
);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|chan_en) |=> (cnt == '0 && div == '0));

    // R3
    div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div <= ps_act);

    // R3
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_en) && div == ps_act && cnt != '1) |=> cnt == CNT_W'($past(cnt) + 1));

    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_en) && div != ps_act) |=> $stable(cnt));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);

    // R8
    live_ps_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_en) && !wrap) |=> $stable(ps_act));

    // R8
    live_cmp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_en) && !wrap) |=> $stable(cmp_act));
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .cnt     (tick_cnt),
    .div     (tick_div),
    .ps_act  (ps_act),
    .cmp_act (cmp_act),
    .wrap    (period_wrap)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] chan_en = '0;
    logic [3:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase_req = "R1";

    // behavioural reference state
    int m_ps_st, m_ps_act, m_div, m_cnt;
    int m_cmp_st[4];
    int m_cmp_act[4];

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .chan_en(chan_en), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk("watchdog", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // reference model: staged writes, shared tick counter, load at wrap or idle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ps_st = 0; m_ps_act = 0; m_div = 0; m_cnt = 0;
            for (int k = 0; k < 4; k++) begin m_cmp_st[k] = 0; m_cmp_act[k] = 0; end
        end else begin
            int old_ps;
            int old_cmp[4];
            bit run, load;
            run = (chan_en != 0);
            load = !run || (m_div == m_ps_act && m_cnt == 255);
            old_ps = m_ps_st;
            for (int k = 0; k < 4; k++) old_cmp[k] = m_cmp_st[k];
            if (wr_en) begin
                if (wr_addr == 0) m_ps_st = (m_ps_st & 'hF0) | (int'(wr_data) & 'h0F);
                else if (wr_addr == 1) m_ps_st = (m_ps_st & 'h0F) | ((int'(wr_data) & 'h0F) << 4);
                else if (wr_addr >= 2 && wr_addr <= 5) m_cmp_st[int'(wr_addr) - 2] = int'(wr_data);
            end
            if (!run) begin
                m_div = 0; m_cnt = 0;
            end else if (m_div == m_ps_act) begin
                m_div = 0;
                m_cnt = (m_cnt + 1) % 256;
            end else begin
                m_div = m_div + 1;
            end
            if (load) begin
                m_ps_act = old_ps;
                for (int k = 0; k < 4; k++) m_cmp_act[k] = old_cmp[k];
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 4; k++)
                chk(phase_req, int'(pwm_out[k]),
                    int'(chan_en[k] && (m_cnt <= m_cmp_act[k])));
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_en(input logic [3:0] m);
        @(posedge clk); #1;
        chan_en = m;
    endtask

    // finds the next rising edge, then returns high samples and period length
    task automatic meas(input int ch, output int hi, output int per);
        bit prev, cur;
        @(negedge clk); prev = pwm_out[ch];
        forever begin
            @(negedge clk); cur = pwm_out[ch];
            if (cur && !prev) break;
            prev = cur;
        end
        hi = 1; per = 1; prev = 1'b1;
        forever begin
            @(negedge clk); cur = pwm_out[ch];
            if (cur && !prev) break;
            per++;
            if (cur) hi++;
            prev = cur;
        end
    endtask

    task automatic count_low(input int ch, input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!pwm_out[ch]) lows++;
        end
    endtask

    initial begin
        int hi, per, lows, rise_cyc, h;
        bit [3:0] prev_v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: outputs low after reset, defaults are zero
        phase_req = "R1";
        repeat (3) @(negedge clk);
        chk("R1 outputs low", int'(pwm_out), 0);
        set_en(4'b0001);
        meas(0, hi, per);
        chk("R1 default high", hi, 1);
        chk("R1 default period", per, 256);

        // R2/R3/R5: prescaler nibbles, upper data bits ignored
        phase_req = "R2";
        wr(0, 'hF3);
        meas(0, hi, per);
        chk("R3 period ps=3", per, 1024);
        chk("R5 one tick ps=3", hi, 4);
        wr(1, 'h01);
        meas(0, hi, per);
        chk("R2 high nibble period", per, 5120);
        chk("R5 one tick ps=19", hi, 20);
        wr(0, 'h20);
        meas(0, hi, per);
        chk("R2 low nibble only", per, 4352);
        wr(1, 0);
        wr(0, 1);
        meas(0, hi, per);
        chk("R3 period ps=1", per, 512);

        // R4/R10: compare values per channel
        phase_req = "R4";
        wr(3, 10);
        wr(4, 100);
        set_en(4'b0111);
        meas(1, hi, per);
        chk("R4 ch1 high", hi, 22);
        chk("R4 ch1 period", per, 512);
        meas(2, hi, per);
        chk("R10 ch2 high", hi, 202);

        // R6: 255 holds high
        phase_req = "R6";
        wr(5, 255);
        set_en(4'b1111);
        meas(0, hi, per);
        count_low(3, 1100, lows);
        chk("R6 never low", lows, 0);

        // R7: aligned rise
        phase_req = "R7";
        prev_v = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out[1] && !prev_v[1]) break;
            prev_v = pwm_out;
        end
        chk("R7 rise together", int'(pwm_out[2:0]), 7);
        chk("R7 low before", int'(prev_v[2:0]), 0);

        // R8: mid-period write waits for wrap
        phase_req = "R8";
        rise_cyc = cyc;
        wr(3, 50);
        while (pwm_out[1]) @(negedge clk);
        chk("R8 old pulse kept", cyc - rise_cyc, 22);
        meas(1, hi, per);
        chk("R8 new pulse", hi, 102);
        // idle pass-through
        set_en(4'b0000);
        wr(3, 7);
        set_en(4'b0010);
        h = 0;
        forever begin
            @(negedge clk);
            if (pwm_out[1]) h++; else break;
        end
        chk("R8 idle load", h, 16);

        // R9: disable gates output, counter keeps running
        phase_req = "R9";
        set_en(4'b0111);
        set_en(4'b0101);
        count_low(1, 600, lows);
        chk("R9 disabled low", lows, 600);
        meas(0, hi, per);
        chk("R9 counter runs", per, 512);
        set_en(4'b0000);
        repeat (3) @(negedge clk);
        chk("R9 all off", int'(pwm_out), 0);

        // R10: unmapped addresses ignored
        phase_req = "R10";
        set_en(4'b1100);
        wr(6, 0);
        wr(7, 0);
        meas(2, hi, per);
        chk("R10 ch2 unchanged", hi, 202);
        chk("R10 period unchanged", per, 512);
        count_low(3, 600, lows);
        chk("R10 ch3 unchanged", lows, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule